// File: doc/BRIEF.md
# Reference Clock Input Selector with Squelch

This block sits in front of a clock-synthesis PLL and picks one of four reference sources to feed it. Sources 0, 1 and 2 are general clock inputs. Source 3 is the crystal or external-oscillator port, which can optionally be divided down by 1, 2, 4 or 8. The active source comes either from a pair of select pins or from a select field written by software. A mode bit decides which of the two is used. The select pins are synchronized into the system clock domain before they are used.

Every reference is sampled in the system clock domain, and an activity monitor watches each one. A source is declared dead when no rising edge has been seen for a programmable number of system cycles. If the chosen source is dead or disabled, the block does not fall over to another input. It raises squelch and holds the reference output low. After any change of selection, and after any loss of the chosen source, the new source must stay valid for a fixed qualification time before squelch is released. A four-bit enable field gates inputs 0 to 2 (bits 0 to 2) and the feedback input (bit 3).

Top module: `refsel_squelch`

## Requirements
- R1: Select code 2'b00 routes input 0, 2'b01 routes input 1, 2'b10 routes input 2 and 2'b11 routes the crystal port to `ref_out`. `ref_out` then carries one rising edge for each rising edge of the routed source (after the crystal pre-scale).
- R2: When `cfg_reg_mode` is 1, the select field `cfg_sel` chooses the source and the pins are ignored. When it is 0, the pins `sel_pin` choose the source and `cfg_sel` is ignored.
- R3: The select pins pass through a two-flop synchronizer. A pin change that is set up before system edge k is not visible on `sel_active` after edge k+1, and is visible after edge k+2.
- R4: After reset, `squelch` is 1, `ref_out` is 0 and `in_alive` is 4'b0000.
- R5: `in_alive[i]` goes to 1 the cycle after a synchronized rising edge of input i. It drops to 0 once `cfg_loss_limit` system cycles have passed with no edge.
- R6: When the selected source has no clock, `squelch` goes to 1 and `ref_out` stays 0. `sel_active` keeps the chosen source, so there is no automatic switch to another input. Squelch is released only after the clock returns and stays valid for the qualification time.
- R7: Any change of `sel_active` raises `squelch` in the same cycle. Squelch stays up for QUAL_CYCLES cycles of continuous validity of the new source.
- R8: Selecting input i (i in 0..2) while `cfg_in_en[i]` is 0 squelches the same way as a dead clock. The crystal port has no enable bit. `fb_out` equals `fb_in` when `cfg_in_en[3]` is 1 and is 0 otherwise.
- R9: The crystal-port pre-scale code `cfg_xtal_div` sets a divide ratio of 2^code (1, 2, 4 or 8). Edges on the divided signal only follow crystal rising edges.
- R10: `ref_out` is 0 in every cycle that follows a cycle in which `squelch` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 4 | Reference sources; bit 3 is the crystal port |
| fb_in | input | 1 | Feedback clock input |
| sel_pin | input | 2 | Asynchronous select pins |
| cfg_reg_mode | input | 1 | 1 = select from cfg_sel, 0 = from pins |
| cfg_sel | input | 2 | Register select field |
| cfg_in_en | input | 4 | Enables: bits 0..2 inputs, bit 3 feedback |
| cfg_xtal_div | input | 2 | Crystal pre-scale code, divide by 2^code |
| cfg_loss_limit | input | LOSS_W | Cycles without an edge before a source is declared dead |
| ref_out | output | 1 | Selected, qualified reference (sampled domain) |
| squelch | output | 1 | 1 while the output is shut off |
| sel_active | output | 2 | Selection currently in effect |
| in_alive | output | 4 | Per-source activity flags |
| fb_out | output | 1 | Enable-gated feedback clock |

## Verification
A wrong source decode or a wrong pre-scale tap shows up at `ref_out` as an edge count that does not match the routed source's rate over a window of a few hundred cycles. A broken synchronizer shows as `sel_active` moving one edge too early or too late. A qualification counter that skips its reset lets `squelch` drop within a handful of cycles of a selection change, instead of after QUAL_CYCLES. A stuck loss counter keeps `in_alive` high well past `cfg_loss_limit`, and because of that `squelch` fails to rise after a source stops.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int NUM_SRC  = 4;
  localparam int SEL_W    = 2;
  localparam int DIV_W    = 2;
  localparam int DIV_MAXK = 3;
  localparam logic [SEL_W-1:0] XTAL_IDX = 2'd3;

  typedef logic [SEL_W-1:0] sel_t;

  // Divided crystal tap: code 0 passes the level, code k takes counter bit k-1.
  function automatic logic div_tap(input logic [DIV_W-1:0] code,
                                   input logic level,
                                   input logic [DIV_MAXK-1:0] cnt);
    logic r;
    if (code == '0) r = level;
    else            r = cnt[code - 1'b1];
    return r;
  endfunction

  // Enable lookup: the crystal port is always enabled.
  function automatic logic src_enabled(input logic [NUM_SRC-1:0] en,
                                       input sel_t sel);
    logic r;
    if (sel == XTAL_IDX) r = 1'b1;
    else                 r = en[sel];
    return r;
  endfunction
endpackage

// File: rtl/refsel_activity.sv
module refsel_activity #(
  parameter int LOSS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_raw,
  input  logic [LOSS_W-1:0] loss_limit,
  output logic              level,
  output logic              rise,
  output logic              alive
);
  localparam logic [LOSS_W-1:0] CNT_MAX = '1;

  logic s1, s2, s3;
  logic [LOSS_W-1:0] gap_cnt, gap_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ref_raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign rise  = s2 & ~s3;

  always_comb begin
    if (rise)                 gap_next = '0;
    else if (gap_cnt == CNT_MAX) gap_next = CNT_MAX;
    else                      gap_next = gap_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= CNT_MAX;
      alive   <= 1'b0;
    end else begin
      gap_cnt <= gap_next;
      alive   <= (gap_next < loss_limit);
    end
  end

  AST_EDGE_REVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && loss_limit != '0) |=> alive); // R5

  AST_DEAD_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_cnt >= loss_limit) |-> !alive); // R5
endmodule

// File: rtl/refsel_prescale.sv
module refsel_prescale
  import refsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] code,
  input  logic             xt_level,
  input  logic             xt_rise,
  output logic             div_out
);
  logic [DIV_MAXK-1:0] edge_cnt, edge_next;

  assign edge_next = xt_rise ? edge_cnt + 1'b1 : edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
      div_out  <= 1'b0;
    end else begin
      edge_cnt <= edge_next;
      div_out  <= div_tap(code, xt_level, edge_next);
    end
  end

  AST_DIV_FOLLOWS_XTAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(div_out) && $stable(code)) |-> $past(xt_rise)); // R9
endmodule

// File: rtl/refsel_qualify.sv
module refsel_qualify
  import refsel_pkg::*;
#(
  parameter int QUAL_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  sel_t want_sel,
  input  logic src_valid,
  output sel_t sel_q,
  output logic squelch
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

  logic [QW-1:0] qual_cnt;
  logic          sel_moved;

  assign sel_moved = (want_sel != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      qual_cnt <= '0;
    end else begin
      sel_q <= want_sel;
      if (sel_moved || !src_valid) qual_cnt <= '0;
      else if (qual_cnt != QMAX)   qual_cnt <= qual_cnt + 1'b1;
    end
  end

  assign squelch = (qual_cnt != QMAX);

  AST_SWITCH_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> squelch); // R7

  AST_INVALID_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> squelch); // R6
endmodule

// File: rtl/refsel_squelch.sv
module refsel_squelch
  import refsel_pkg::*;
#(
  parameter int LOSS_W      = 16,
  parameter int QUAL_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        ref_in,
  input  logic              fb_in,
  input  logic [1:0]        sel_pin,
  input  logic              cfg_reg_mode,
  input  logic [1:0]        cfg_sel,
  input  logic [3:0]        cfg_in_en,
  input  logic [1:0]        cfg_xtal_div,
  input  logic [LOSS_W-1:0] cfg_loss_limit,
  output logic              ref_out,
  output logic              squelch,
  output logic [1:0]        sel_active,
  output logic [3:0]        in_alive,
  output logic              fb_out
);
  logic [NUM_SRC-1:0] src_level, src_rise, src_feed;
  sel_t pin_s1, pin_s2, want_sel, sel_q;
  logic xt_div, src_valid, sq;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_mon
      refsel_activity #(.LOSS_W(LOSS_W)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_raw    (ref_in[gi]),
        .loss_limit (cfg_loss_limit),
        .level      (src_level[gi]),
        .rise       (src_rise[gi]),
        .alive      (in_alive[gi])
      );
      if (gi == int'(XTAL_IDX)) begin : g_xt
        assign src_feed[gi] = xt_div;
      end else begin : g_gen
        assign src_feed[gi] = src_level[gi];
      end
    end
  endgenerate

  refsel_prescale u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .code     (cfg_xtal_div),
    .xt_level (src_level[XTAL_IDX]),
    .xt_rise  (src_rise[XTAL_IDX]),
    .div_out  (xt_div)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
    end else begin
      pin_s1 <= sel_pin;
      pin_s2 <= pin_s1;
    end
  end

  assign want_sel  = cfg_reg_mode ? cfg_sel : pin_s2;
  assign src_valid = src_enabled(cfg_in_en, sel_q) & in_alive[sel_q];

  refsel_qualify #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_sel  (want_sel),
    .src_valid (src_valid),
    .sel_q     (sel_q),
    .squelch   (sq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_out <= 1'b0;
    else        ref_out <= ~sq & src_feed[sel_q];
  end

  assign squelch    = sq;
  assign sel_active = sel_q;
  assign fb_out     = fb_in & cfg_in_en[3];

  AST_MUTED_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sq) |-> !ref_out); // R10

  AST_REG_MODE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_reg_mode) |-> (sel_q == $past(cfg_sel))); // R2

  AST_FB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_in_en[3] |-> !fb_out); // R8
endmodule

// File: tb/refsel_squelch_test.sv
module refsel_squelch_test;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 16;
  localparam int LIMIT = 10;
  localparam int WIN = 480;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ref_in;
  logic fb_in = 1'b0;
  logic [1:0] sel_pin = 2'd0, cfg_sel = 2'd0, cfg_xtal_div = 2'd0;
  logic cfg_reg_mode = 1'b1;
  logic [3:0] cfg_in_en = 4'hF;
  logic [15:0] cfg_loss_limit = 16'(LIMIT);
  logic ref_out, squelch, fb_out;
  logic [1:0] sel_active;
  logic [3:0] in_alive;

  logic [3:0] run = 4'hF;
  int tick = 0;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick = tick + 1;
    ref_in[0] = run[0] & ((tick / 2) % 2 == 1);
    ref_in[1] = run[1] & ((tick % 6) < 3);
    ref_in[2] = run[2] & ((tick / 4) % 2 == 1);
    ref_in[3] = run[3] & ((tick / 2) % 2 == 1);
  end

  refsel_squelch #(.LOSS_W(16), .QUAL_CYCLES(QUAL)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .sel_pin(sel_pin),
    .cfg_reg_mode(cfg_reg_mode), .cfg_sel(cfg_sel), .cfg_in_en(cfg_in_en),
    .cfg_xtal_div(cfg_xtal_div), .cfg_loss_limit(cfg_loss_limit),
    .ref_out(ref_out), .squelch(squelch), .sel_active(sel_active),
    .in_alive(in_alive), .fb_out(fb_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected rising edges of the routed source over a window.
  function automatic int exp_edges(input int sel, input int div, input int win);
    int period;
    case (sel)
      0: period = 4;
      1: period = 6;
      2: period = 8;
      default: period = 4 * (1 << div);
    endcase
    return win / period;
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_open(input int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!squelch) begin ok = 1'b1; break; end
    end
  endtask

  task automatic count_edges(input int win, output int n);
    logic prev;
    n = 0;
    prev = ref_out;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (ref_out && !prev) n++;
      prev = ref_out;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    int n, e;
    cycles(3);
    // R4 reset state
    chk(squelch === 1'b1, "R4 squelch", squelch, 1);
    chk(ref_out === 1'b0, "R4 ref_out", ref_out, 0);
    chk(in_alive === 4'b0, "R4 in_alive", in_alive, 0);
    rst_n = 1'b1;
    cycles(2);
    chk(squelch === 1'b1, "R4 squelch early", squelch, 1);

    // R1 R2: sweep both modes and all codes, other route set to a different code
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        cfg_reg_mode = m[0];
        if (m == 1) begin cfg_sel = s[1:0]; sel_pin = ~s[1:0]; end
        else        begin sel_pin = s[1:0]; cfg_sel = ~s[1:0]; end
        cycles(5);
        wait_open(200, ok);
        chk(ok, "R1 qualify", ok, 1);
        chk(sel_active == s[1:0], "R2 route", sel_active, s);
        count_edges(WIN, n);
        e = exp_edges(s, 0, WIN);
        chk(n >= e - 1 && n <= e + 1, "R1 edge count", n, e);
      end
    end

    // R9 prescale sweep on the crystal port
    cfg_reg_mode = 1'b1; cfg_sel = 2'd3;
    for (int d = 0; d < 4; d++) begin
      cfg_xtal_div = d[1:0];
      cycles(40);
      count_edges(WIN, n);
      e = exp_edges(3, d, WIN);
      chk(n >= e - 1 && n <= e + 1, "R9 divided edges", n, e);
    end
    cfg_xtal_div = 2'd0;

    // R3 pin synchronizer latency
    cfg_reg_mode = 1'b0; sel_pin = 2'd0;
    cycles(5);
    wait_open(200, ok);
    @(negedge clk); sel_pin = 2'd1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(sel_active == 2'd0, "R3 not yet", sel_active, 0);
    @(posedge clk); #1;
    chk(sel_active == 2'd1, "R3 visible", sel_active, 1);

    // R7 qualification after a change
    cfg_reg_mode = 1'b1; cfg_sel = 2'd1;
    cycles(5);
    wait_open(200, ok);
    @(negedge clk); cfg_sel = 2'd0;
    cycles(1);
    chk(squelch === 1'b1, "R7 switch squelch", squelch, 1);
    cycles(QUAL - 3);
    chk(squelch === 1'b1, "R7 hold", squelch, 1);
    cycles(8);
    chk(squelch === 1'b0, "R7 release", squelch, 0);

    // R5 R6 loss of the selected clock
    run[0] = 1'b0;
    cycles(3);
    chk(in_alive[0] === 1'b1, "R5 still alive", in_alive[0], 1);
    cycles(LIMIT + 10);
    chk(in_alive[0] === 1'b0, "R5 declared dead", in_alive[0], 0);
    chk(squelch === 1'b1, "R6 squelch", squelch, 1);
    chk(ref_out === 1'b0, "R10 output low", ref_out, 0);
    chk(sel_active == 2'd0, "R6 no fallover", sel_active, 0);
    run[0] = 1'b1;
    cycles(8);
    chk(in_alive[0] === 1'b1, "R5 revived", in_alive[0], 1);
    wait_open(QUAL + 20, ok);
    chk(ok, "R6 release", ok, 1);

    // R8 enables
    cfg_in_en[0] = 1'b0;
    cycles(3);
    chk(squelch === 1'b1, "R8 disabled squelch", squelch, 1);
    cycles(QUAL + 10);
    chk(squelch === 1'b1, "R8 stays squelched", squelch, 1);
    cfg_in_en = 4'h0; cfg_sel = 2'd3;
    cycles(5);
    wait_open(200, ok);
    chk(ok, "R8 crystal no enable", ok, 1);
    fb_in = 1'b1; #1;
    chk(fb_out === 1'b0, "R8 fb gated", fb_out, 0);
    cfg_in_en[3] = 1'b1; #1;
    chk(fb_out === 1'b1, "R8 fb pass", fb_out, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule